// File: doc/BRIEF.md
# Function-Unit Wait Matrix

This block tracks, for every function unit of an out-of-order core, which other units it must wait for before it may read its operands or write its result. The state is a square bit matrix with one row per unit, split into two planes of equal size. The write-wait plane of row *i* lists the units whose pending results unit *i* must see before it reads. The read-wait plane of row *i* lists the units whose pending operand reads must finish before unit *i* writes. The row number is the unit's identity, so no tag is stored and nothing is matched against stored entry numbers.

When a unit issues, its row in both planes is loaded in a single cycle from two wait vectors supplied by the issue logic. When a unit completes or is cancelled, a pulse on its bit of `done_vec` removes it from every other row's wait set and empties its own row. Each unit's readiness is a wide NOR over its own row. "May read" comes from the write-wait plane and "may write" comes from the read-wait plane. Both are registered and change one cycle after the event that causes them.

Top module: `fu_dep_matrix`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every wait bit is clear and `may_read` and `may_write` are all ones.
- R2: With `issue_valid` high, the row selected by `issue_unit` (binary unit index) is loaded in both planes from `issue_wr_wait` and `issue_rd_wait` at the next clock edge.
- R3: `may_read[i]` is 1 exactly when no bit of row *i* of the write-wait plane is set.
- R4: `may_write[i]` is 1 exactly when no bit of row *i* of the read-wait plane is set.
- R5: A 1 on bit *k* of `done_vec` clears column *k* in every row of both planes.
- R6: A 1 on bit *k* of `done_vec` clears all of row *k* in both planes, unless unit *k* issues in the same cycle.
- R7: A unit never waits on itself: bit *i* of the issue vectors is discarded when row *i* is loaded.
- R8: An issue to one unit and completions of other units in the same cycle both take effect.
- R9: When unit *k* issues and `done_vec[k]` is 1 in the same cycle, the row is loaded and the row clear is not applied.
- R10: A wait bit for unit *k* in the issue vectors is not recorded if `done_vec[k]` is 1 in the same cycle.
- R11: With `issue_valid` low, `issue_unit`, `issue_rd_wait` and `issue_wr_wait` have no effect.
- R12: The readiness outputs are registered, so they change at the clock edge that applies the event and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Load the row of `issue_unit` this cycle |
| issue_unit | input | UNIT_W | Binary index of the issuing unit |
| issue_rd_wait | input | N_UNITS | Units whose pending reads block this unit's write |
| issue_wr_wait | input | N_UNITS | Units whose pending writes block this unit's read |
| done_vec | input | N_UNITS | Completion or cancel pulses, one bit per unit |
| may_read | output | N_UNITS | Unit has no outstanding write-wait |
| may_write | output | N_UNITS | Unit has no outstanding read-wait |

## Verification
Assertions check the following on every cycle:
- The diagonal of both planes stays empty.
- Each readiness bit agrees with the NOR of its stored row.
- A completion leaves its column empty in every row.
- A completion without a same-cycle issue leaves its own row empty.
- An issued row holds exactly the masked issue vectors.

The interplay of sequences can only be shown by the bench's scenarios:
- A dependency that persists until one particular unit finishes.
- A stale wait bit dropped because its producer completed in the issue cycle.
- An issue that overrides its own row clear.
- Long random mixes of issue and completion compared against a reference model at the ports.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  // Upper bound for unit counts handled by the helper below
  parameter int unsigned FDM_MAX_UNITS = 64;

  typedef logic [FDM_MAX_UNITS-1:0] fdm_wide_t;

  // One-hot vector with only bit idx set
  function automatic fdm_wide_t unit_mask(input int unsigned idx);
    fdm_wide_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fdm_row.sv
// One row of both wait planes with its next-state logic
module fdm_row #(
  parameter int unsigned N   = 8,
  parameter int unsigned ROW = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] rd_in,
  input  logic [N-1:0] wr_in,
  input  logic [N-1:0] done_vec,
  output logic [N-1:0] rd_row,
  output logic [N-1:0] wr_row,
  output logic [N-1:0] rd_nxt,
  output logic [N-1:0] wr_nxt
);
  localparam fdm_pkg::fdm_wide_t SELF_W = fdm_pkg::unit_mask(ROW);
  localparam logic [N-1:0]       SELF   = SELF_W[N-1:0];

  always_comb begin
    if (load) begin
      // issue wins over the row clear; self and finishing units dropped
      rd_nxt = rd_in & ~done_vec & ~SELF;
      wr_nxt = wr_in & ~done_vec & ~SELF;
    end else if (done_vec[ROW]) begin
      rd_nxt = '0;
      wr_nxt = '0;
    end else begin
      rd_nxt = rd_row & ~done_vec;
      wr_nxt = wr_row & ~done_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_row <= '0;
      wr_row <= '0;
    end else begin
      rd_row <= rd_nxt;
      wr_row <= wr_nxt;
    end
  end
endmodule

// File: rtl/fdm_ready.sv
// Registered NOR reductions across each row of the next-state planes
module fdm_ready #(
  parameter int unsigned N = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][N-1:0] rd_nxt,
  input  logic [N-1:0][N-1:0] wr_nxt,
  output logic [N-1:0]        may_read,
  output logic [N-1:0]        may_write
);
  logic [N-1:0] rd_free, wr_free;

  for (genvar r = 0; r < N; r++) begin : g_nor
    assign rd_free[r] = ~|wr_nxt[r];
    assign wr_free[r] = ~|rd_nxt[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      may_read  <= '1;
      may_write <= '1;
    end else begin
      may_read  <= rd_free;
      may_write <= wr_free;
    end
  end
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
  parameter int unsigned N_UNITS = 8,
  parameter int unsigned UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_valid,
  input  logic [UNIT_W-1:0]  issue_unit,
  input  logic [N_UNITS-1:0] issue_rd_wait,
  input  logic [N_UNITS-1:0] issue_wr_wait,
  input  logic [N_UNITS-1:0] done_vec,
  output logic [N_UNITS-1:0] may_read,
  output logic [N_UNITS-1:0] may_write
);
  logic [N_UNITS-1:0]              load_vec;
  logic [N_UNITS-1:0][N_UNITS-1:0] rd_plane, wr_plane;
  logic [N_UNITS-1:0][N_UNITS-1:0] rd_next, wr_next;

  // Binary issue index to one-hot row load
  for (genvar r = 0; r < N_UNITS; r++) begin : g_dec
    assign load_vec[r] = issue_valid && (issue_unit == UNIT_W'(r));
  end

  for (genvar r = 0; r < N_UNITS; r++) begin : g_row
    fdm_row #(.N(N_UNITS), .ROW(r)) u_row (
      .clk      (clk),
      .rst      (rst),
      .load     (load_vec[r]),
      .rd_in    (issue_rd_wait),
      .wr_in    (issue_wr_wait),
      .done_vec (done_vec),
      .rd_row   (rd_plane[r]),
      .wr_row   (wr_plane[r]),
      .rd_nxt   (rd_next[r]),
      .wr_nxt   (wr_next[r])
    );
  end

  fdm_ready #(.N(N_UNITS)) u_ready (
    .clk       (clk),
    .rst       (rst),
    .rd_nxt    (rd_next),
    .wr_nxt    (wr_next),
    .may_read  (may_read),
    .may_write (may_write)
  );
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int unsigned N  = 8,
  parameter int unsigned UW = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                issue_valid,
  input logic [UW-1:0]       issue_unit,
  input logic [N-1:0]        issue_rd_wait,
  input logic [N-1:0]        issue_wr_wait,
  input logic [N-1:0]        done_vec,
  input logic [N-1:0]        may_read,
  input logic [N-1:0]        may_write,
  input logic [N-1:0][N-1:0] rd_plane,
  input logic [N-1:0][N-1:0] wr_plane
);
  // R1: outputs all ready right after reset
  a_r1_reset_ready: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&may_read && &may_write && rd_plane == '0 && wr_plane == '0));

  for (genvar r = 0; r < N; r++) begin : g_r
    // R3
    a_r3_read_nor: assert property (@(posedge clk) disable iff (rst)
      may_read[r] == (wr_plane[r] == '0));
    // R4
    a_r4_write_nor: assert property (@(posedge clk) disable iff (rst)
      may_write[r] == (rd_plane[r] == '0));
    // R7
    a_r7_no_self: assert property (@(posedge clk) disable iff (rst)
      !rd_plane[r][r] && !wr_plane[r][r]);
    // R6 (and R9 through the issue exemption)
    a_r6_row_clear: assert property (@(posedge clk) disable iff (rst)
      (done_vec[r] && !(issue_valid && issue_unit == UW'(r)))
        |=> (rd_plane[r] == '0 && wr_plane[r] == '0));
    // R2 with R10 masking
    a_r2_issue_load: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && issue_unit == UW'(r))
        |=> (wr_plane[r] == ($past(issue_wr_wait) & ~$past(done_vec) & ~(N'(1) << r))
          && rd_plane[r] == ($past(issue_rd_wait) & ~$past(done_vec) & ~(N'(1) << r))));
    for (genvar k = 0; k < N; k++) begin : g_k
      // R5
      a_r5_col_clear: assert property (@(posedge clk) disable iff (rst)
        done_vec[k] |=> (!rd_plane[r][k] && !wr_plane[r][k]));
    end
  end
endmodule

bind fu_dep_matrix fdm_checker #(.N(N_UNITS), .UW(UNIT_W)) u_fdm_checker (
  .clk           (clk),
  .rst           (rst),
  .issue_valid   (issue_valid),
  .issue_unit    (issue_unit),
  .issue_rd_wait (issue_rd_wait),
  .issue_wr_wait (issue_wr_wait),
  .done_vec      (done_vec),
  .may_read      (may_read),
  .may_write     (may_write),
  .rd_plane      (rd_plane),
  .wr_plane      (wr_plane)
);

// File: tb/test_fu_dep_matrix.sv
module test_fu_dep_matrix;
  localparam int N  = 8;
  localparam int UW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issue_valid = 1'b0;
  logic [UW-1:0] issue_unit = '0;
  logic [N-1:0]  issue_rd_wait = '0;
  logic [N-1:0]  issue_wr_wait = '0;
  logic [N-1:0]  done_vec = '0;
  logic [N-1:0]  may_read, may_write;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference planes
  logic [N-1:0] m_rd [N];
  logic [N-1:0] m_wr [N];

  // scoreboard queues
  logic [N-1:0] q_rd [$];
  logic [N-1:0] q_wr [$];
  string        q_tag [$];

  always #5 clk = ~clk;

  fu_dep_matrix #(.N_UNITS(N)) i_fu_dep_matrix (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_unit(issue_unit),
    .issue_rd_wait(issue_rd_wait), .issue_wr_wait(issue_wr_wait),
    .done_vec(done_vec), .may_read(may_read), .may_write(may_write)
  );

  task automatic check(input string tag, input logic [N-1:0] act_r, input logic [N-1:0] exp_r,
                       input logic [N-1:0] act_w, input logic [N-1:0] exp_w);
    checks++;
    if (act_r !== exp_r || act_w !== exp_w) begin
      errors++;
      $display("FAIL %s: may_read=%b may_write=%b expected may_read=%b may_write=%b",
               tag, act_r, act_w, exp_r, exp_w);
    end
  endtask

  // driver: drive at negedge, update model, push expectation
  task automatic apply(input bit iv, input int iu, input logic [N-1:0] rdi,
                       input logic [N-1:0] wri, input logic [N-1:0] dn, input string tag);
    logic [N-1:0] er, ew;
    @(negedge clk);
    issue_valid   = iv;
    issue_unit    = UW'(iu);
    issue_rd_wait = rdi;
    issue_wr_wait = wri;
    done_vec      = dn;
    for (int r = 0; r < N; r++) begin
      logic [N-1:0] self;
      self = '0;
      self[r] = 1'b1;
      if (iv && iu == r) begin
        m_rd[r] = rdi & ~dn & ~self;
        m_wr[r] = wri & ~dn & ~self;
      end else if (dn[r]) begin
        m_rd[r] = '0;
        m_wr[r] = '0;
      end else begin
        m_rd[r] = m_rd[r] & ~dn;
        m_wr[r] = m_wr[r] & ~dn;
      end
      er[r] = (m_wr[r] == '0);
      ew[r] = (m_rd[r] == '0);
    end
    q_rd.push_back(er);
    q_wr.push_back(ew);
    q_tag.push_back(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (q_tag.size() > 0) begin
      logic [N-1:0] er, ew;
      string t;
      er = q_rd.pop_front();
      ew = q_wr.pop_front();
      t  = q_tag.pop_front();
      check(t, may_read, er, may_write, ew);
    end
  end

  function automatic logic [N-1:0] bits(input int a, input int b);
    logic [N-1:0] v;
    v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    return v;
  endfunction

  initial begin
    #(10 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) begin
      m_rd[r] = '0;
      m_wr[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", may_read, '1, may_write, '1);

    // R12: nothing visible before the edge
    apply(1, 2, bits(1, -1), bits(0, 5), '0, "R2 issue unit 2");
    #1;
    check("R12 before edge", may_read, '1, may_write, '1);
    apply(0, 4, '1, '1, '0, "R11 idle with junk inputs");
    apply(0, 0, '0, '0, bits(1, -1), "R4 read wait cleared");
    apply(0, 0, '0, '0, bits(5, -1), "R5 column 5 cleared");
    apply(1, 6, bits(6, -1), bits(6, -1), '0, "R7 self bit ignored");
    apply(0, 0, '0, '0, bits(0, -1), "R3 last write wait cleared");
    apply(1, 2, '0, bits(7, -1), '0, "R2 reissue unit 2");
    apply(0, 0, '0, '0, bits(2, -1), "R6 row 2 cleared");
    apply(1, 5, '0, bits(3, -1), '0, "R2 issue unit 5");
    apply(1, 4, bits(5, -1), bits(1, -1), bits(0, -1), "R8 issue and done together");
    apply(1, 1, '0, bits(7, -1), bits(1, -1), "R9 issue beats row clear");
    apply(1, 3, '0, bits(6, 7), bits(7, -1), "R10 finishing producer dropped");
    apply(0, 0, '0, '0, bits(6, -1), "R10 remaining wait cleared");
    apply(0, 0, '0, '0, '1, "R5 all units done");

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] dn;
      dn = '0;
      for (int b = 0; b < N; b++) dn[b] = ($urandom % 8 == 0);
      apply(($urandom % 2) == 1, int'($urandom % N), N'($urandom & $urandom),
            N'($urandom & $urandom), dn, "R3 R4 random mix");
    end
    apply(0, 0, '0, '0, '0, "R3 final idle");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule